// File: doc/BRIEF.md
# Multi-Step Instruction Control Sequencer

This block is the control unit of a small machine with an 8-bit data bus and a 16-bit address bus. It walks a phase counter through a fixed fetch-and-advance prefix that every instruction shares. During that prefix it reads the opcode byte from the data bus into its own instruction register. It then runs a step sequence chosen by the opcode class. In every step it drives registered strobes: a one-hot source select for each bus, load enables for the destination registers, memory read and write requests, and the ALU function. The datapath registers, the ALU and the memory sit outside the block and simply obey the strobes.

Instructions with a 16-bit address operand fetch two further bytes, high byte first, into two jump-latch halves. The program counter is advanced past each operand byte. For conditional branches the flags decide only whether the final transfer of the jump latch into the program counter takes place. A halt opcode freezes the block with all strobes inactive until reset.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active high), `step_o` is 0, `halted` is 0, `ld_o` is 0, and the outputs show the first fetch step: `asel_o` = 5'h01 and `mem_rd` = 1.
- R2: Steps 0..5 are the same for every opcode. Steps 0 and 1 select the PC with `mem_rd`. Step 2 adds loads of the instruction register (ld bit 8) and the incrementer (ld bit 10). Step 3 selects the incrementer (asel bit 1). Step 4 does the same and loads the PC (ld bit 9). Step 5 is idle. `step_o` counts up by one each cycle and wraps to 0 after an instruction's last step.
- R3: Encodings. Data-bus select bits 0..7 are A,B,C,D,M1,M2,X,Y, bit 8 is the ALU and bit 9 is the immediate. Address-bus select bits are PC 0, incrementer 1, XY 2, M 3, J 4. Load bits 0..7 are A..Y, then IR 8, PC 9, incrementer 10, XY 11, J1 12, J2 13, condition codes 14. Each select vector has at most one bit set, and `mem_rd` and `mem_wr` are never high together.
- R4: Opcode 00dddsss is an 8-step register copy. Steps 6 and 7 select source sss on the data bus, and step 7 loads destination ddd (codes 0..7 = A..Y).
- R5: Opcode 1000rfff is an 8-step ALU operation. In steps 6 and 7, `alu_en` is high, `alu_fn` = fff and data select bit 8 is set. Step 7 loads A (r=0) or D (r=1) together with the condition codes.
- R6: Opcode 01rddddd is an 8-step immediate load. In steps 6 and 7, data select bit 9 is set and `imm_o` is ddddd sign-extended to 8 bits. Step 7 loads A (r=0) or B (r=1).
- R7: Opcode 100100rr reads memory at M into register rr, with M selected and `mem_rd` high in steps 6 and 7 and the load at step 7. Opcode 100110rr writes register rr to memory at M, with M and rr selected and `mem_wr` high in steps 6 and 7. Both take 8 steps.
- R8: 10110000 (XY increment) takes 10 steps: XY is passed through the incrementer and loaded back. Opcode 1010dss0 (16-bit copy, ss: 00 M, 01 XY, 10 J; d: 0 XY, 1 PC) takes 10 steps and selects the source in steps 8 and 9, loading the destination at step 9.
- R9: 11100110 (jump) takes 16 steps and 11100111 (call) takes 18. Both fetch two operand bytes into J1 then J2, advancing the PC after each. A call loads XY from the PC before J is loaded into the PC.
- R10: Branches take 16 steps: 11110000 on S=1, 11101000 on Cy=1, 11100100 on Z=1, 11100010 on Z=0. When taken, J is selected and the PC loaded at the end. When not taken, J is never selected and the PC is loaded only three times in the instruction.
- R11: Opcode 10101110 raises `halted` on entering step 6. From then on every strobe is 0 and `step_o` holds, whatever the bus carries, until reset.
- R12: Any other opcode takes 7 steps and drives no strobe after the prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Data bus, opcode byte during fetch |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| step_o | output | 5 | Current phase number |
| dsel_o | output | 10 | One-hot data-bus source select |
| asel_o | output | 5 | One-hot address-bus source select |
| ld_o | output | 15 | Register load enables |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| alu_en | output | 1 | ALU result driven onto the data bus |
| alu_fn | output | 3 | ALU function code |
| imm_o | output | 8 | Sign-extended immediate value |
| halted | output | 1 | Halt indicator |

## Verification
The assertions check on every cycle the properties that hold for every opcode: at most one source per bus, no read together with a write, a step counter that only advances by one or wraps, opcode capture only during a memory read from the PC, condition codes loaded only with the ALU on the bus, writes addressed through M, and a halt state that stays quiet and frozen. Only the bench scenarios can show that each opcode class gets the right length, the right destination and source, the right immediate and function code, and the right taken or not-taken tail for each flag. The scenarios also show that reset ends a halt.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NDSEL = 10;
  localparam int NASEL = 5;
  localparam int NLD   = 15;

  localparam int D_ALU = 8;
  localparam int D_IMM = 9;

  localparam int A_PC  = 0;
  localparam int A_INC = 1;
  localparam int A_XY  = 2;
  localparam int A_M   = 3;
  localparam int A_J   = 4;

  localparam int L_IR  = 8;
  localparam int L_PC  = 9;
  localparam int L_INC = 10;
  localparam int L_XY  = 11;
  localparam int L_J1  = 12;
  localparam int L_J2  = 13;
  localparam int L_CC  = 14;

  localparam int EXEC0 = 6;

  typedef enum logic [3:0] {
    K_MOV8, K_ALU, K_LDI, K_INCXY, K_LOAD, K_STORE,
    K_MOV16, K_HALT, K_JUMP, K_CALL, K_BRANCH, K_UNDEF
  } op_kind_e;

  typedef struct packed {
    logic [NDSEL-1:0] dsel;
    logic [NASEL-1:0] asel;
    logic [NLD-1:0]   ld;
    logic             rd;
    logic             wr;
    logic             alu_en;
    logic [2:0]       fn;
  } ctrl_t;
endpackage

// File: rtl/seq_classify.sv
module seq_classify
  import seq_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  logic [7:0]        ir,
  output op_kind_e          kind,
  output logic [STEP_W-1:0] last
);
  always_comb begin
    casez (ir)
      8'b00??????: kind = K_MOV8;
      8'b01??????: kind = K_LDI;
      8'b1000????: kind = K_ALU;
      8'b100100??: kind = K_LOAD;
      8'b100110??: kind = K_STORE;
      8'b10110000: kind = K_INCXY;
      8'b10101110: kind = K_HALT;
      8'b10100110: kind = K_UNDEF;
      8'b1010???0: kind = K_MOV16;
      8'b11100110: kind = K_JUMP;
      8'b11100111: kind = K_CALL;
      8'b11110000,
      8'b11101000,
      8'b11100100,
      8'b11100010: kind = K_BRANCH;
      default:     kind = K_UNDEF;
    endcase
  end

  always_comb begin
    case (kind)
      K_INCXY, K_MOV16:  last = STEP_W'(EXEC0 + 3);
      K_JUMP, K_BRANCH:  last = STEP_W'(EXEC0 + 9);
      K_CALL:            last = STEP_W'(EXEC0 + 11);
      K_UNDEF, K_HALT:   last = STEP_W'(EXEC0);
      default:           last = STEP_W'(EXEC0 + 1);
    endcase
  end
endmodule

// File: rtl/seq_cond.sv
module seq_cond (
  input  logic [7:0] ir,
  input  logic       f_z,
  input  logic       f_c,
  input  logic       f_s,
  output logic       take
);
  always_comb begin
    case (ir)
      8'b11110000: take = f_s;
      8'b11101000: take = f_c;
      8'b11100100: take = f_z;
      8'b11100010: take = ~f_z;
      default:     take = 1'b1;
    endcase
  end
endmodule

// File: rtl/seq_strobe.sv
module seq_strobe
  import seq_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  logic [STEP_W-1:0] step,
  input  op_kind_e          kind,
  input  logic [5:0]        ir6,
  input  logic              take,
  output ctrl_t             ctl,
  output logic [7:0]        imm
);
  int ei;
  always_comb ei = int'(step) - EXEC0;

  always_comb begin
    ctl = '0;
    imm = '0;
    if (step < STEP_W'(EXEC0)) begin
      case (step)
        STEP_W'(0), STEP_W'(1): begin
          ctl.asel[A_PC] = 1'b1;
          ctl.rd = 1'b1;
        end
        STEP_W'(2): begin
          ctl.asel[A_PC] = 1'b1;
          ctl.rd = 1'b1;
          ctl.ld[L_IR] = 1'b1;
          ctl.ld[L_INC] = 1'b1;
        end
        STEP_W'(3): ctl.asel[A_INC] = 1'b1;
        STEP_W'(4): begin
          ctl.asel[A_INC] = 1'b1;
          ctl.ld[L_PC] = 1'b1;
        end
        default: ;
      endcase
    end else begin
      case (kind)
        K_MOV8: if (ei < 2) begin
          ctl.dsel[ir6[2:0]] = 1'b1;
          if (ei == 1) ctl.ld[ir6[5:3]] = 1'b1;
        end
        K_ALU: if (ei < 2) begin
          ctl.alu_en = 1'b1;
          ctl.fn = ir6[2:0];
          ctl.dsel[D_ALU] = 1'b1;
          if (ei == 1) begin
            ctl.ld[ir6[3] ? 3 : 0] = 1'b1;
            ctl.ld[L_CC] = 1'b1;
          end
        end
        K_LDI: if (ei < 2) begin
          ctl.dsel[D_IMM] = 1'b1;
          imm = {{3{ir6[4]}}, ir6[4:0]};
          if (ei == 1) ctl.ld[ir6[5] ? 1 : 0] = 1'b1;
        end
        K_LOAD: if (ei < 2) begin
          ctl.asel[A_M] = 1'b1;
          ctl.rd = 1'b1;
          if (ei == 1) ctl.ld[ir6[1:0]] = 1'b1;
        end
        K_STORE: if (ei < 2) begin
          ctl.asel[A_M] = 1'b1;
          ctl.dsel[ir6[1:0]] = 1'b1;
          ctl.wr = 1'b1;
        end
        K_INCXY: begin
          if (ei < 2) ctl.asel[A_XY] = 1'b1;
          else if (ei < 4) ctl.asel[A_INC] = 1'b1;
          if (ei == 1) ctl.ld[L_INC] = 1'b1;
          if (ei == 3) ctl.ld[L_XY] = 1'b1;
        end
        K_MOV16: if (ei == 2 || ei == 3) begin
          case (ir6[2:1])
            2'b00:   ctl.asel[A_M] = 1'b1;
            2'b01:   ctl.asel[A_XY] = 1'b1;
            2'b10:   ctl.asel[A_J] = 1'b1;
            default: ;
          endcase
          if (ei == 3) ctl.ld[ir6[3] ? L_PC : L_XY] = 1'b1;
        end
        K_JUMP, K_CALL, K_BRANCH: begin
          if (ei < 8) begin
            case (ei[1:0])
              2'd0: begin
                ctl.asel[A_PC] = 1'b1;
                ctl.rd = 1'b1;
              end
              2'd1: begin
                ctl.asel[A_PC] = 1'b1;
                ctl.rd = 1'b1;
                ctl.ld[ei[2] ? L_J2 : L_J1] = 1'b1;
                ctl.ld[L_INC] = 1'b1;
              end
              2'd2: ctl.asel[A_INC] = 1'b1;
              default: begin
                ctl.asel[A_INC] = 1'b1;
                ctl.ld[L_PC] = 1'b1;
              end
            endcase
          end else if (kind == K_CALL) begin
            if (ei < 10) ctl.asel[A_PC] = 1'b1;
            else if (ei < 12) ctl.asel[A_J] = 1'b1;
            if (ei == 9) ctl.ld[L_XY] = 1'b1;
            if (ei == 11) ctl.ld[L_PC] = 1'b1;
          end else if (take && ei < 10) begin
            ctl.asel[A_J] = 1'b1;
            if (ei == 9) ctl.ld[L_PC] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter  int MAX_STEPS = 24,
  localparam int STEP_W    = $clog2(MAX_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bus_data,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_s,
  output logic [STEP_W-1:0] step_o,
  output logic [NDSEL-1:0]  dsel_o,
  output logic [NASEL-1:0]  asel_o,
  output logic [NLD-1:0]    ld_o,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              alu_en,
  output logic [2:0]        alu_fn,
  output logic [7:0]        imm_o,
  output logic              halted
);
  logic [STEP_W-1:0] step_q, step_nxt, last;
  logic [7:0]        ir_q, imm_q, imm_nxt;
  logic              halt_q, take;
  ctrl_t             ctl_q, ctl_nxt;
  op_kind_e          kind;

  seq_classify #(.STEP_W(STEP_W)) u_cls (
    .ir(ir_q), .kind(kind), .last(last)
  );

  seq_cond u_cond (
    .ir(ir_q), .f_z(flag_z), .f_c(flag_c), .f_s(flag_s), .take(take)
  );

  // Strobes are computed for the step about to be entered, so the
  // registered outputs line up with step_q in the same cycle.
  seq_strobe #(.STEP_W(STEP_W)) u_str (
    .step(step_nxt), .kind(kind), .ir6(ir_q[5:0]), .take(take),
    .ctl(ctl_nxt), .imm(imm_nxt)
  );

  always_comb step_nxt = (step_q == last) ? '0 : step_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      ir_q   <= '0;
      halt_q <= 1'b0;
      imm_q  <= '0;
      ctl_q  <= '0;
      ctl_q.asel[A_PC] <= 1'b1;
      ctl_q.rd <= 1'b1;
    end else if (!halt_q) begin
      if (ctl_q.ld[L_IR]) ir_q <= bus_data;
      step_q <= step_nxt;
      if (step_nxt == STEP_W'(EXEC0) && kind == K_HALT) begin
        halt_q <= 1'b1;
        ctl_q  <= '0;
        imm_q  <= '0;
      end else begin
        ctl_q <= ctl_nxt;
        imm_q <= imm_nxt;
      end
    end
  end

  assign step_o = step_q;
  assign dsel_o = ctl_q.dsel;
  assign asel_o = ctl_q.asel;
  assign ld_o   = ctl_q.ld;
  assign mem_rd = ctl_q.rd;
  assign mem_wr = ctl_q.wr;
  assign alu_en = ctl_q.alu_en;
  assign alu_fn = ctl_q.fn;
  assign imm_o  = imm_q;
  assign halted = halt_q;

  assert_dsel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dsel_o));
  assert_asel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(asel_o));
  assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!halted && step_o != '0) |-> (step_o == STEP_W'($past(step_o) + 1'b1)));
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
    step_o < STEP_W'(MAX_STEPS));
  assert_ir_on_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    ld_o[L_IR] |-> (asel_o[A_PC] && mem_rd));
  assert_cc_with_alu_R5: assert property (@(posedge clk) disable iff (rst)
    ld_o[L_CC] |-> (alu_en && dsel_o[D_ALU]));
  assert_wr_via_m_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> asel_o[A_M]);
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    halted |-> (ld_o == '0 && dsel_o == '0 && asel_o == '0 && !mem_rd && !mem_wr && !alu_en));
  assert_halt_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(step_o)));
endmodule

// File: tb/instr_sequencer_tb.sv
module instr_sequencer_tb;
  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  flg;   // {s, c, z}
    logic [4:0]  len;
    logic [14:0] ld;    // loads seen in steps 6 and later
    logic [9:0]  dsel;  // data selects seen in steps 6 and later
    logic [4:0]  asel;  // address selects seen in steps 6 and later
    logic [3:0]  rd;    // read cycles over the whole instruction
    logic [1:0]  wr;
    logic [1:0]  alu;
    logic [2:0]  fn;
    logic [7:0]  imm;
    logic [2:0]  pcl;   // PC loads over the whole instruction
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{8'h0A,3'b000,5'd8, 15'h0002,10'h004,5'h00,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'h3C,3'b000,5'd8, 15'h0080,10'h010,5'h00,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'h07,3'b000,5'd8, 15'h0001,10'h080,5'h00,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'h8C,3'b000,5'd8, 15'h4008,10'h100,5'h00,4'd3,2'd0,2'd2,3'd4,8'h00,3'd1},
    '{8'h80,3'b000,5'd8, 15'h4001,10'h100,5'h00,4'd3,2'd0,2'd2,3'd0,8'h00,3'd1},
    '{8'h86,3'b000,5'd8, 15'h4001,10'h100,5'h00,4'd3,2'd0,2'd2,3'd6,8'h00,3'd1},
    '{8'h70,3'b000,5'd8, 15'h0002,10'h200,5'h00,4'd3,2'd0,2'd0,3'd0,8'hF0,3'd1},
    '{8'h4F,3'b000,5'd8, 15'h0001,10'h200,5'h00,4'd3,2'd0,2'd0,3'd0,8'h0F,3'd1},
    '{8'h5F,3'b000,5'd8, 15'h0001,10'h200,5'h00,4'd3,2'd0,2'd0,3'd0,8'hFF,3'd1},
    '{8'hB0,3'b000,5'd10,15'h0C00,10'h000,5'h06,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'h92,3'b000,5'd8, 15'h0004,10'h000,5'h08,4'd5,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'h9B,3'b000,5'd8, 15'h0000,10'h008,5'h08,4'd3,2'd2,2'd0,3'd0,8'h00,3'd1},
    '{8'hAA,3'b000,5'd10,15'h0200,10'h000,5'h04,4'd3,2'd0,2'd0,3'd0,8'h00,3'd2},
    '{8'hA4,3'b000,5'd10,15'h0800,10'h000,5'h10,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'hA0,3'b000,5'd10,15'h0800,10'h000,5'h08,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'hE6,3'b000,5'd16,15'h3600,10'h000,5'h13,4'd7,2'd0,2'd0,3'd0,8'h00,3'd4},
    '{8'hE7,3'b000,5'd18,15'h3E00,10'h000,5'h13,4'd7,2'd0,2'd0,3'd0,8'h00,3'd4},
    '{8'hF0,3'b100,5'd16,15'h3600,10'h000,5'h13,4'd7,2'd0,2'd0,3'd0,8'h00,3'd4},
    '{8'hF0,3'b011,5'd16,15'h3600,10'h000,5'h03,4'd7,2'd0,2'd0,3'd0,8'h00,3'd3},
    '{8'hE8,3'b010,5'd16,15'h3600,10'h000,5'h13,4'd7,2'd0,2'd0,3'd0,8'h00,3'd4},
    '{8'hE8,3'b101,5'd16,15'h3600,10'h000,5'h03,4'd7,2'd0,2'd0,3'd0,8'h00,3'd3},
    '{8'hE4,3'b001,5'd16,15'h3600,10'h000,5'h13,4'd7,2'd0,2'd0,3'd0,8'h00,3'd4},
    '{8'hE4,3'b110,5'd16,15'h3600,10'h000,5'h03,4'd7,2'd0,2'd0,3'd0,8'h00,3'd3},
    '{8'hE2,3'b000,5'd16,15'h3600,10'h000,5'h13,4'd7,2'd0,2'd0,3'd0,8'h00,3'd4},
    '{8'hE2,3'b001,5'd16,15'h3600,10'h000,5'h03,4'd7,2'd0,2'd0,3'd0,8'h00,3'd3},
    '{8'hFF,3'b000,5'd7, 15'h0000,10'h000,5'h00,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'hA6,3'b000,5'd7, 15'h0000,10'h000,5'h00,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1},
    '{8'hB1,3'b000,5'd7, 15'h0000,10'h000,5'h00,4'd3,2'd0,2'd0,3'd0,8'h00,3'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_data = 8'h00;
  logic        flag_z = 1'b0, flag_c = 1'b0, flag_s = 1'b0;
  logic [4:0]  step_o;
  logic [9:0]  dsel_o;
  logic [4:0]  asel_o;
  logic [14:0] ld_o;
  logic        mem_rd, mem_wr, alu_en, halted;
  logic [2:0]  alu_fn;
  logic [7:0]  imm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  instr_sequencer u_dut (
    .clk(clk), .rst(rst), .bus_data(bus_data),
    .flag_z(flag_z), .flag_c(flag_c), .flag_s(flag_s),
    .step_o(step_o), .dsel_o(dsel_o), .asel_o(asel_o), .ld_o(ld_o),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_en(alu_en), .alu_fn(alu_fn),
    .imm_o(imm_o), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] op);
    casez (op)
      8'b00??????: return "R4";
      8'b01??????: return "R6";
      8'b1000????: return "R5";
      8'b100?10??: return "R7";
      8'b10110000: return "R8";
      8'b1010?0?0, 8'b10101010: return "R8";
      8'b1110011?: return "R9";
      8'b11110000, 8'b11101000, 8'b11100100, 8'b11100010: return "R10";
      default: return "R12";
    endcase
  endfunction

  // {asel, rd, ld} expected in the shared prefix (R2)
  function automatic logic [20:0] pre_exp(input int s);
    case (s)
      0, 1:    return {5'h01, 1'b1, 15'h0000};
      2:       return {5'h01, 1'b1, 15'h0500};
      3:       return {5'h02, 1'b0, 15'h0000};
      4:       return {5'h02, 1'b0, 15'h0200};
      default: return {5'h00, 1'b0, 15'h0000};
    endcase
  endfunction

  // Call at a negedge where step_o is 0; returns at the next step 0.
  task automatic run_vec(input vec_t v);
    int n = 0, rd = 0, wr = 0, alu = 0, pcl = 0;
    logic [14:0] ldo = '0;
    logic [9:0]  dso = '0;
    logic [4:0]  aso = '0;
    logic [7:0]  gimm = '0;
    logic [2:0]  gfn = '0;
    bit prebad = 1'b0;
    string rq = req_of(v.op);
    bus_data = v.op;
    {flag_s, flag_c, flag_z} = v.flg;
    do begin
      if (step_o < 6) begin
        if ({asel_o, mem_rd, ld_o} != pre_exp(int'(step_o)) || dsel_o != '0) prebad = 1'b1;
      end else begin
        ldo |= ld_o; dso |= dsel_o; aso |= asel_o;
      end
      if (mem_rd) rd++;
      if (mem_wr) wr++;
      if (alu_en) begin alu++; gfn = alu_fn; end
      if (dsel_o[9]) gimm = imm_o;
      if (ld_o[9]) pcl++;
      n++;
      @(negedge clk);
    end while (step_o != 0 && n < 40);
    chk(!prebad, "R2", $sformatf("prefix strobes op %0h", v.op), prebad, 0);
    chk(n == int'(v.len), rq, $sformatf("length op %0h", v.op), n, v.len);
    chk(ldo == v.ld, rq, $sformatf("loads op %0h", v.op), ldo, v.ld);
    chk(dso == v.dsel, rq, $sformatf("data select op %0h", v.op), dso, v.dsel);
    chk(aso == v.asel, rq, $sformatf("addr select op %0h", v.op), aso, v.asel);
    chk(rd == int'(v.rd), rq, $sformatf("read cycles op %0h", v.op), rd, v.rd);
    chk(wr == int'(v.wr), rq, $sformatf("write cycles op %0h", v.op), wr, v.wr);
    chk(alu == int'(v.alu), rq, $sformatf("alu cycles op %0h", v.op), alu, v.alu);
    chk(gfn == v.fn, rq, $sformatf("alu fn op %0h", v.op), gfn, v.fn);
    chk(gimm == v.imm, rq, $sformatf("immediate op %0h", v.op), gimm, v.imm);
    chk(pcl == int'(v.pcl), rq, $sformatf("PC loads op %0h", v.op), pcl, v.pcl);
  endtask

  task automatic check_reset_state();
    chk(step_o == 0, "R1", "reset step", step_o, 0);
    chk(halted == 1'b0, "R1", "reset halted", halted, 0);
    chk(asel_o == 5'h01 && mem_rd && ld_o == '0, "R1", "reset fetch strobes",
        {asel_o, mem_rd, ld_o}, {5'h01, 1'b1, 15'h0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: halt freezes everything until reset
    bus_data = 8'hAE;
    repeat (12) @(negedge clk);
    chk(halted == 1'b1, "R11", "halted raised", halted, 1);
    chk(step_o == 6, "R11", "halt step held", step_o, 6);
    chk({ld_o, dsel_o, asel_o, mem_rd, mem_wr, alu_en} == '0, "R11", "halt strobes",
        {ld_o, dsel_o, asel_o, mem_rd, mem_wr, alu_en}, 0);
    bus_data = 8'h80;
    flag_z = 1'b1;
    repeat (10) @(negedge clk);
    chk(halted == 1'b1 && step_o == 6, "R11", "halt ignores bus",
        {halted, step_o}, {1'b1, 5'd6});
    chk({ld_o, dsel_o, asel_o, mem_rd, mem_wr, alu_en} == '0, "R11", "halt strobes later",
        {ld_o, dsel_o, asel_o, mem_rd, mem_wr, alu_en}, 0);

    // R1: reset ends halt and restarts fetch
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run_vec(VECS[3]);

    // R1: reset in the middle of a jump operand fetch
    bus_data = 8'hE6;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run_vec(VECS[0]);
    run_vec(VECS[16]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule